// File: doc/BRIEF.md
# Zero-Crossing Gated Volume Updater

This block sits between a serial control port and a stepped gain stage. Each time the control port finishes a write, it presents one new 8-bit volume code per channel together with a one-cycle latch strobe. The block decides when each code becomes the active code that drives the gain stage. It also turns the active code into a mute flag and a signed gain in half-dB steps.

In immediate mode the code takes effect on the latch strobe itself. In zero-cross mode each channel holds its code as pending. It applies the code at the first sign change of its own 16-bit sample stream that follows the strobe. If no sign change arrives within a 20 ms window, counted in clock cycles and derived from the clock frequency, the code is applied anyway. Switching the gain only at a zero crossing of the waveform avoids audible clicks on large steps.

The gain mapping depends on a static input-configuration selector. Each code step is 0.5 dB. Code 00h always means mute.

Top module: `zc_volume_updater`

## Requirements
- R1: After reset every channel reports mute_o=1, gain_o=0 and applied_o=0.
- R2: With zc_mode_i low, a latch_i strobe copies code_i into the active code on that same clock edge. applied_o is high for the following cycle, and mute_o and gain_o reflect the new code in that cycle.
- R3: With zc_mode_i high, a latched code is held pending. The active code, mute_o and gain_o stay unchanged while no crossing and no timeout occurs.
- R4: A crossing is a sample accepted with smp_valid_i that either equals zero or has a sign bit (bit 15) different from the previous accepted sample. Only crossings in cycles after the latch cycle count. A crossing applies the pending code on that edge and pulses applied_o.
- R5: A pending code with no crossing is applied on the clock edge CLK_HZ/50 cycles after the latch edge.
- R6: A latch strobe while a code is pending replaces the pending code and restarts the timeout count.
- R7: Each channel waits for its own crossing. A crossing on one channel does not apply the other channel's pending code.
- R8: Code 00h gives mute_o=1 and gain_o=0. It follows the same immediate or zero-cross timing as any other code.
- R9: gain_o is the signed half-dB value code-191-offset. The offset is 0 for cfg_sel_i=0 or 3, 5 for cfg_sel_i=1, and 24 for cfg_sel_i=2. So FFh gives +64, 59 and 40, and 01h gives -190, -195 and -214.
- R10: If zc_mode_i is low while a code is pending, the code is applied on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zc_mode_i | input | 1 | 1 = wait for zero crossing, 0 = apply at once |
| cfg_sel_i | input | 2 | Input configuration selecting the gain offset |
| latch_i | input | 1 | One-cycle strobe marking a completed write |
| code_i | input | NUM_CH*CODE_W | New volume code per channel |
| smp_valid_i | input | 1 | Sample strobe shared by all channels |
| smp_i | input | NUM_CH*SMP_W | Signed sample per channel |
| mute_o | output | NUM_CH | Active code is the mute code |
| gain_o | output | NUM_CH*GAIN_W | Signed gain in half-dB units, 0 when muted |
| applied_o | output | NUM_CH | One-cycle pulse on each update of the active code |

## Verification
The hardest cases to reach are the timeout path and the re-latch case. Both need a pending code to survive many cycles with no crossing while valid samples keep arriving. The bench holds each channel's samples at a constant sign and shortens the window by lowering the clock-frequency parameter. It re-latches part way through the window and samples the outputs just before and just after the expected update edge. Channel independence is shown by flipping the sign on one channel only, then sending an exact zero on the other.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
  typedef enum logic [1:0] {
    CFG_FULL = 2'd0,
    CFG_LOW  = 2'd1,
    CFG_WIDE = 2'd2,
    CFG_ALT  = 2'd3
  } zcv_cfg_e;

  localparam int OFS_LOW  = 5;
  localparam int OFS_WIDE = 24;
endpackage

// File: rtl/zcv_zero_detect.sv
module zcv_zero_detect #(
  parameter int SMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic             zc_o
);
  logic prev_neg_q, seen_q;
  logic cur_neg;

  assign cur_neg = smp_i[SMP_W-1];
  assign zc_o = valid_i && ((smp_i == '0) || (seen_q && (cur_neg != prev_neg_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_neg_q <= 1'b0;
      seen_q     <= 1'b0;
    end else if (valid_i) begin
      prev_neg_q <= cur_neg;
      seen_q     <= 1'b1;
    end
  end

  a_r4_sign_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && $past(valid_i) && $past(rst_ni) &&
    (smp_i[SMP_W-1] != $past(smp_i[SMP_W-1])) |-> zc_o);

  a_r4_zero_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (smp_i == '0) |-> zc_o);
endmodule

// File: rtl/zcv_update_gate.sv
module zcv_update_gate #(
  parameter int CODE_W = 8,
  parameter int TO_CYC = 4000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_mode_i,
  input  logic              latch_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              zc_i,
  output logic [CODE_W-1:0] active_o,
  output logic              applied_o
);
  localparam int TMR_W = $clog2(TO_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TO_CYC - 1);

  logic              pend_q;
  logic [CODE_W-1:0] pend_code_q;
  logic [TMR_W-1:0]  timer_q;
  logic              fire;

  // pending code leaves on a crossing, on expiry, or when the mode drops
  assign fire = pend_q && (!zc_mode_i || zc_i || (timer_q == TMR_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_code_q <= '0;
      timer_q     <= '0;
      active_o    <= '0;
      applied_o   <= 1'b0;
    end else begin
      applied_o <= 1'b0;
      if (latch_i) begin
        if (!zc_mode_i) begin
          active_o  <= code_i;
          applied_o <= 1'b1;
          pend_q    <= 1'b0;
        end else begin
          pend_q      <= 1'b1;
          pend_code_q <= code_i;
          timer_q     <= '0;
        end
      end else if (fire) begin
        active_o  <= pend_code_q;
        applied_o <= 1'b1;
        pend_q    <= 1'b0;
      end else if (pend_q) begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  a_r2_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !zc_mode_i && latch_i |=> applied_o && (active_o == $past(code_i)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_mode_i && pend_q && !latch_i && !zc_i && (timer_q != TMR_LAST)
    |=> !applied_o && $stable(active_o));

  a_r4_cross_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_mode_i && pend_q && !latch_i && zc_i
    |=> applied_o && (active_o == $past(pend_code_q)));

  a_r5_timer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_q <= TMR_LAST);

  a_r6_relatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zc_mode_i && latch_i |=> pend_q && !applied_o && (timer_q == '0));
endmodule

// File: rtl/zcv_gain_decode.sv
module zcv_gain_decode
  import zcv_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int GAIN_W    = 9,
  parameter int ZERO_CODE = 191
) (
  input  logic [CODE_W-1:0] code_i,
  input  zcv_cfg_e          cfg_i,
  output logic              mute_o,
  output logic [GAIN_W-1:0] gain_o
);
  int ofs_v;
  int gain_v;

  always_comb begin
    case (cfg_i)
      CFG_LOW:  ofs_v = OFS_LOW;
      CFG_WIDE: ofs_v = OFS_WIDE;
      default:  ofs_v = 0;
    endcase
    gain_v = int'(code_i) - ZERO_CODE - ofs_v;
    mute_o = (code_i == '0);
    gain_o = mute_o ? '0 : gain_v[GAIN_W-1:0];
  end
endmodule

// File: rtl/zc_volume_updater.sv
module zc_volume_updater
  import zcv_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CODE_W    = 8,
  parameter int SMP_W     = 16,
  parameter int CLK_HZ    = 200000000,
  parameter int ZERO_CODE = 191,
  parameter int GAIN_W    = CODE_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           zc_mode_i,
  input  logic [1:0]                     cfg_sel_i,
  input  logic                           latch_i,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  code_i,
  input  logic                           smp_valid_i,
  input  logic [NUM_CH-1:0][SMP_W-1:0]   smp_i,
  output logic [NUM_CH-1:0]              mute_o,
  output logic [NUM_CH-1:0][GAIN_W-1:0]  gain_o,
  output logic [NUM_CH-1:0]              applied_o
);
  localparam int TO_CYC = CLK_HZ / 50;  // 20 ms window

  zcv_cfg_e cfg;
  assign cfg = zcv_cfg_e'(cfg_sel_i);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              zc;
    logic [CODE_W-1:0] active;

    zcv_zero_detect #(.SMP_W(SMP_W)) u_zc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (smp_valid_i),
      .smp_i   (smp_i[ch]),
      .zc_o    (zc)
    );

    zcv_update_gate #(.CODE_W(CODE_W), .TO_CYC(TO_CYC)) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .zc_mode_i (zc_mode_i),
      .latch_i   (latch_i),
      .code_i    (code_i[ch]),
      .zc_i      (zc),
      .active_o  (active),
      .applied_o (applied_o[ch])
    );

    zcv_gain_decode #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .ZERO_CODE(ZERO_CODE)) u_dec (
      .code_i (active),
      .cfg_i  (cfg),
      .mute_o (mute_o[ch]),
      .gain_o (gain_o[ch])
    );

    a_r8_mute_zero_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mute_o[ch] |-> (gain_o[ch] == '0));
  end
endmodule

// File: tb/zc_volume_updater_tb_top.sv
module zc_volume_updater_tb_top;
  localparam int NUM_CH = 2;
  localparam int CODE_W = 8;
  localparam int SMP_W  = 16;
  localparam int GAIN_W = 9;
  localparam int CLK_HZ = 5000;
  localparam int TO     = CLK_HZ / 50;

  typedef struct packed {
    logic [1:0] cfg;
    logic [7:0] code;
    logic       mute;
    int         gain;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{2'd0, 8'hFF, 1'b0,   64},
    '{2'd0, 8'h01, 1'b0, -190},
    '{2'd0, 8'hBF, 1'b0,    0},
    '{2'd0, 8'h00, 1'b1,    0},
    '{2'd1, 8'hFF, 1'b0,   59},
    '{2'd1, 8'h01, 1'b0, -195},
    '{2'd2, 8'hFF, 1'b0,   40},
    '{2'd2, 8'h01, 1'b0, -214},
    '{2'd2, 8'hD7, 1'b0,    0},
    '{2'd3, 8'h80, 1'b0,  -63}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic zc_mode = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic latch = 1'b0;
  logic [NUM_CH-1:0][CODE_W-1:0] code = '0;
  logic smp_valid = 1'b0;
  logic [NUM_CH-1:0][SMP_W-1:0] smp = '0;
  logic [NUM_CH-1:0] mute, applied;
  logic [NUM_CH-1:0][GAIN_W-1:0] gain;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  zc_volume_updater #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .SMP_W(SMP_W), .CLK_HZ(CLK_HZ)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .zc_mode_i(zc_mode), .cfg_sel_i(cfg_sel),
    .latch_i(latch), .code_i(code), .smp_valid_i(smp_valid), .smp_i(smp),
    .mute_o(mute), .gain_o(gain), .applied_o(applied)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int g(input int ch);
    return int'($signed(gain[ch]));
  endfunction

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic do_latch(input logic [7:0] c0, input logic [7:0] c1);
    code[0] = c0;
    code[1] = c1;
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 mute0", int'(mute[0]), 1);
    check("R1 mute1", int'(mute[1]), 1);
    check("R1 gain0", g(0), 0);
    check("R1 applied", int'(applied), 0);
    rst_n = 1'b1;
    smp[0] = 16'd100;
    smp[1] = 16'd100;
    smp_valid = 1'b1;
    repeat (3) @(negedge clk);

    // R2/R8/R9 table walk in immediate mode
    for (int i = 0; i < 10; i++) begin
      cfg_sel = VEC[i].cfg;
      do_latch(VEC[i].code, VEC[i].code);
      check("R2 applied0", int'(applied[0]), 1);
      check("R8 mute0", int'(mute[0]), int'(VEC[i].mute));
      check("R9 gain0", g(0), VEC[i].gain);
      check("R9 gain1", g(1), VEC[i].gain);
      @(negedge clk);
      check("R2 pulse ends", int'(applied[0]), 0);
    end

    // R10: pending code released when mode drops
    cfg_sel = 2'd0;
    do_latch(8'h80, 8'h80);
    zc_mode = 1'b1;
    do_latch(8'h20, 8'h20);
    repeat (3) @(negedge clk);
    check("R3 hold", g(0), -63);
    zc_mode = 1'b0;
    @(negedge clk);
    check("R10 applied", int'(applied[0]), 1);
    check("R10 gain", g(0), -159);

    // R3/R4/R7: per-channel crossings
    zc_mode = 1'b1;
    do_latch(8'h40, 8'h60);
    repeat (5) @(negedge clk);
    check("R3 hold0", g(0), -159);
    check("R3 hold1", g(1), -159);
    smp[0] = -16'sd100;
    @(negedge clk);
    check("R4 sign flip ch0", g(0), -127);
    check("R4 applied ch0", int'(applied[0]), 1);
    check("R7 ch1 waits", g(1), -159);
    check("R7 ch1 no pulse", int'(applied[1]), 0);
    smp[1] = 16'd0;
    @(negedge clk);
    check("R4 zero sample ch1", g(1), -95);
    smp[1] = 16'd50;
    @(negedge clk);

    // R5: timeout
    do_latch(8'hC0, 8'hC0);
    repeat (TO - 2) @(negedge clk);
    check("R5 before expiry", g(0), -127);
    repeat (2) @(negedge clk);
    check("R5 expiry gain", g(0), 1);
    check("R5 expiry pulse", int'(applied[0]), 1);
    check("R5 expiry ch1", g(1), 1);

    // R6: re-latch restarts the window
    do_latch(8'h10, 8'h10);
    repeat (60) @(negedge clk);
    do_latch(8'h30, 8'h30);
    repeat (50) @(negedge clk);
    check("R6 restarted", g(0), 1);
    repeat (52) @(negedge clk);
    check("R6 replaced code", g(0), -143);

    // R8: mute in zero-cross mode
    do_latch(8'h00, 8'h00);
    repeat (3) @(negedge clk);
    check("R8 mute waits", int'(mute[0]), 0);
    smp[0] = 16'd100;
    @(negedge clk);
    check("R8 mute on crossing", int'(mute[0]), 1);
    check("R8 muted gain", g(0), 0);
    check("R8 ch1 still waiting", int'(mute[1]), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule